// File: doc/BRIEF.md
# Five-Lane Serial Deserializer with Per-Lane Bit Normalization

This block takes five slow serial streams, each with its own serial clock and data line, and turns each stream into 32-bit words. Every lane samples its serial clock on a fast system clock, shifts one data bit into a plain shift register on each detected rising edge, and emits a word after 32 bits. The equipment feeding the lanes scrambles the same logical data into a different bit order on each lane. A fixed per-lane bit map, applied as wiring to the completed word, puts all five lanes back into one common order.

Each lane groups its words into frames of 13 and its frames into bursts of 10. Every emitted word carries a one-cycle valid strobe, its position within the frame and the frame's position within the burst. A burst-done strobe marks the last word of a burst. The bit maps are a compile-time parameter that holds 32 source indices per lane. Elaboration stops with an error if any lane's map is not a true permutation. Later stages, such as a byte lookup or moving the data off chip, connect to these outputs.

Top module: `lane_deser_top`

## Requirements
- R1: A synchronous active-high reset clears every lane. After reset, `word_valid_o`, `burst_done_o`, `word_o`, `word_idx_o` and `frame_idx_o` are all zero. Bits already shifted in are discarded, and the next word counts as word 0 of frame 0.
- R2: Each lane's serial clock passes through a two-flop synchronizer. One data bit is taken on each detected rising edge of that clock. The new bit enters bit 0 and the older bits move one place toward the MSB, so the first of the 32 bits ends at bit 31. Changes on a data line with no rising serial clock edge have no effect.
- R3: After the 32nd rising edge, a lane raises `word_valid_o` for exactly one system clock cycle. Each group of 32 bits produces exactly one word.
- R4: Output bit j of lane c equals bit MAP[c][j] of the captured word. The default map is MAP[c][j] = (j*(2c+1) + 3c) mod 32, so lane 0 passes the word through unchanged.
- R5: `word_idx_o` counts 0 to 12 over successive words of a lane and wraps to 0 after 12.
- R6: `frame_idx_o` holds the frame number, 0 to 9. It advances by one on the word after each word 12 and wraps to 0 after frame 9.
- R7: `burst_done_o` is high only together with `word_valid_o`, and only on the 130th word of a burst, which has word index 12 and frame index 9. The next word has word index 0 and frame index 0.
- R8: The lanes are independent. Activity on one lane produces no word and changes no counter on any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 5 | Serial clock, one bit per lane |
| sdat_i | input | 5 | Serial data, one bit per lane |
| word_valid_o | output | 5 | One-cycle strobe per lane when a word is presented |
| word_o | output | 5x32 | Normalized word per lane |
| word_idx_o | output | 5x4 | Word position within the frame, 0 to 12 |
| frame_idx_o | output | 5x4 | Frame position within the burst, 0 to 9 |
| burst_done_o | output | 5 | Strobe on the last word of a burst |

## Verification
A word with only bit 31 and bit 0 set, followed by a dense pattern, is sent on a single lane while the other lanes stay idle. This shows the shift direction and lane independence, because any word on a silent lane is an error. Random words on all five lanes at once check that each lane's own map is applied: a swapped or shifted map corrupts the normalized bits on that lane alone. Data toggling with no serial clock edge, a reset in the middle of a word, and a run of 133 words check that stray data is ignored, that partial bits are dropped, and that the frame and burst counters wrap with exactly one burst-done strobe.

// File: rtl/lane_deser_pkg.sv
package lane_deser_pkg;
  localparam int LANES  = 5;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef logic [IDX_W-1:0]   src_idx_t;
  typedef src_idx_t [WORD_W-1:0] lane_map_t;
  typedef lane_map_t [LANES-1:0] map_t;
  typedef logic [WORD_W-1:0]  word_t;

  // Default per-lane maps: an odd stride plus a rotation is always a permutation.
  function automatic map_t default_map();
    map_t m;
    for (int c = 0; c < LANES; c++)
      for (int j = 0; j < WORD_W; j++)
        m[c][j] = src_idx_t'((j * (2 * c + 1) + 3 * c) % WORD_W);
    return m;
  endfunction

  function automatic bit map_is_perm(map_t m);
    logic [WORD_W-1:0] seen;
    for (int c = 0; c < LANES; c++) begin
      seen = '0;
      for (int j = 0; j < WORD_W; j++) seen[m[c][j]] = 1'b1;
      if (seen != {WORD_W{1'b1}}) return 1'b0;
    end
    return 1'b1;
  endfunction
endpackage

// File: rtl/lane_edge_sync.sv
module lane_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic sdat,
  output logic rise,
  output logic dat
);
  logic [STAGES:0]   sclk_pipe;
  logic [STAGES-1:0] dat_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_pipe <= '0;
      dat_pipe  <= '0;
    end else begin
      sclk_pipe <= {sclk_pipe[STAGES-1:0], sclk};
      dat_pipe  <= {dat_pipe[STAGES-2:0], sdat};
    end
  end

  assign rise = sclk_pipe[STAGES-1] & ~sclk_pipe[STAGES];
  assign dat  = dat_pipe[STAGES-1];
endmodule

// File: rtl/lane_capture.sv
module lane_capture
  import lane_deser_pkg::*;
#(
  parameter lane_map_t MAP = default_map()
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  shift,
  input  logic  bit_in,
  output logic  word_valid,
  output word_t word_o
);
  localparam int LAST = WORD_W - 1;

  word_t    shreg;
  word_t    nxt;
  word_t    perm;
  src_idx_t cnt;

  always_comb begin
    nxt = {shreg[WORD_W-2:0], bit_in};
    for (int j = 0; j < WORD_W; j++) perm[j] = nxt[MAP[j]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      word_o     <= '0;
    end else begin
      word_valid <= 1'b0;
      if (shift) begin
        shreg <= nxt;
        if (cnt == src_idx_t'(LAST)) begin
          cnt        <= '0;
          word_valid <= 1'b1;
          word_o     <= perm;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_framer.sv
module lane_framer
  import lane_deser_pkg::*;
#(
  parameter int WORDS_PER_FRAME  = 13,
  parameter int FRAMES_PER_BURST = 10,
  localparam int WIDX_W = $clog2(WORDS_PER_FRAME),
  localparam int FIDX_W = $clog2(FRAMES_PER_BURST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  word_t             in_word,
  output logic              out_valid,
  output word_t             out_word,
  output logic [WIDX_W-1:0] out_widx,
  output logic [FIDX_W-1:0] out_fidx,
  output logic              out_done
);
  logic [WIDX_W-1:0] w_cnt;
  logic [FIDX_W-1:0] f_cnt;
  logic last_w, last_f;

  assign last_w = (w_cnt == WIDX_W'(WORDS_PER_FRAME - 1));
  assign last_f = (f_cnt == FIDX_W'(FRAMES_PER_BURST - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      w_cnt     <= '0;
      f_cnt     <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_widx  <= '0;
      out_fidx  <= '0;
      out_done  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_done  <= 1'b0;
      if (in_valid) begin
        out_word <= in_word;
        out_widx <= w_cnt;
        out_fidx <= f_cnt;
        if (last_w) begin
          w_cnt <= '0;
          if (last_f) begin
            f_cnt    <= '0;
            out_done <= 1'b1;
          end else begin
            f_cnt <= f_cnt + 1'b1;
          end
        end else begin
          w_cnt <= w_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_deser_top.sv
module lane_deser_top
  import lane_deser_pkg::*;
#(
  parameter int   WORDS_PER_FRAME  = 13,
  parameter int   FRAMES_PER_BURST = 10,
  parameter int   SYNC_STAGES      = 2,
  parameter map_t BIT_MAP          = default_map(),
  localparam int  WIDX_W = $clog2(WORDS_PER_FRAME),
  localparam int  FIDX_W = $clog2(FRAMES_PER_BURST)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0]              sclk_i,
  input  logic [LANES-1:0]              sdat_i,
  output logic [LANES-1:0]              word_valid_o,
  output logic [LANES-1:0][WORD_W-1:0]  word_o,
  output logic [LANES-1:0][WIDX_W-1:0]  word_idx_o,
  output logic [LANES-1:0][FIDX_W-1:0]  frame_idx_o,
  output logic [LANES-1:0]              burst_done_o
);
  if (!map_is_perm(BIT_MAP)) begin : g_bad_map
    $error("lane_deser_top: BIT_MAP holds a lane that is not a permutation");
  end

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    logic  rise, dat, cap_valid;
    word_t cap_word;

    lane_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .sclk(sclk_i[c]), .sdat(sdat_i[c]),
      .rise(rise), .dat(dat)
    );

    lane_capture #(.MAP(BIT_MAP[c])) i_cap (
      .clk(clk), .rst(rst), .shift(rise), .bit_in(dat),
      .word_valid(cap_valid), .word_o(cap_word)
    );

    lane_framer #(
      .WORDS_PER_FRAME(WORDS_PER_FRAME), .FRAMES_PER_BURST(FRAMES_PER_BURST)
    ) i_frm (
      .clk(clk), .rst(rst), .in_valid(cap_valid), .in_word(cap_word),
      .out_valid(word_valid_o[c]), .out_word(word_o[c]),
      .out_widx(word_idx_o[c]), .out_fidx(frame_idx_o[c]),
      .out_done(burst_done_o[c])
    );
  end
endmodule

// File: rtl/lane_deser_chk.sv
module lane_deser_chk
  import lane_deser_pkg::*;
#(
  parameter int  WORDS_PER_FRAME  = 13,
  parameter int  FRAMES_PER_BURST = 10,
  localparam int WIDX_W = $clog2(WORDS_PER_FRAME),
  localparam int FIDX_W = $clog2(FRAMES_PER_BURST)
) (
  input logic                         clk,
  input logic                         rst,
  input logic [LANES-1:0]             word_valid_o,
  input logic [LANES-1:0][WIDX_W-1:0] word_idx_o,
  input logic [LANES-1:0][FIDX_W-1:0] frame_idx_o,
  input logic [LANES-1:0]             burst_done_o
);
  for (genvar c = 0; c < LANES; c++) begin : g_chk
    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      word_valid_o[c] |=> !word_valid_o[c]);
    // R5
    widx_range_chk: assert property (@(posedge clk) disable iff (rst)
      word_valid_o[c] |-> (word_idx_o[c] < WIDX_W'(WORDS_PER_FRAME)));
    // R6
    fidx_range_chk: assert property (@(posedge clk) disable iff (rst)
      word_valid_o[c] |-> (frame_idx_o[c] < FIDX_W'(FRAMES_PER_BURST)));
    // R7
    done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
      burst_done_o[c] |-> word_valid_o[c]);
    // R7
    done_at_last_chk: assert property (@(posedge clk) disable iff (rst)
      burst_done_o[c] |-> (word_idx_o[c] == WIDX_W'(WORDS_PER_FRAME - 1) &&
                           frame_idx_o[c] == FIDX_W'(FRAMES_PER_BURST - 1)));
  end
endmodule

bind lane_deser_top lane_deser_chk #(
  .WORDS_PER_FRAME(WORDS_PER_FRAME), .FRAMES_PER_BURST(FRAMES_PER_BURST)
) i_chk (
  .clk(clk), .rst(rst), .word_valid_o(word_valid_o), .word_idx_o(word_idx_o),
  .frame_idx_o(frame_idx_o), .burst_done_o(burst_done_o)
);

// File: tb/test_lane_deser_top.sv
module test_lane_deser_top;
  localparam int NL = 5;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NL-1:0]        sclk_i = '0;
  logic [NL-1:0]        sdat_i = '0;
  logic [NL-1:0]        word_valid_o;
  logic [NL-1:0][31:0]  word_o;
  logic [NL-1:0][3:0]   word_idx_o;
  logic [NL-1:0][3:0]   frame_idx_o;
  logic [NL-1:0]        burst_done_o;

  lane_deser_top i_lane_deser_top (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .word_valid_o(word_valid_o), .word_o(word_o), .word_idx_o(word_idx_o),
    .frame_idx_o(frame_idx_o), .burst_done_o(burst_done_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [31:0] q_word [NL][$];
  int          q_widx [NL][$];
  int          q_fidx [NL][$];
  bit          q_done [NL][$];
  int          bw [NL];
  int          bf [NL];
  int          seen_valid [NL];
  int          seen_done  [NL];
  logic [NL-1:0] prev_valid = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] norm(input int c, input logic [31:0] raw);
    logic [31:0] o;
    for (int j = 0; j < 32; j++) o[j] = raw[(j * (2 * c + 1) + 3 * c) % 32];
    return o;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NL; c++) begin
      bw[c] = 0; bf[c] = 0;
      q_word[c].delete(); q_widx[c].delete(); q_fidx[c].delete(); q_done[c].delete();
    end
  endtask

  task automatic push_exp(input int c, input logic [31:0] raw);
    q_word[c].push_back(norm(c, raw));
    q_widx[c].push_back(bw[c]);
    q_fidx[c].push_back(bf[c]);
    q_done[c].push_back(bw[c] == 12 && bf[c] == 9);
    bw[c]++;
    if (bw[c] == 13) begin
      bw[c] = 0; bf[c]++;
      if (bf[c] == 10) bf[c] = 0;
    end
  endtask

  // Send nbits MSB first on the lanes in en; push expectations when a word completes.
  task automatic send(input logic [NL-1:0] en, input logic [31:0] w [NL], input int nbits, input bit push);
    for (int b = 31; b > 31 - nbits; b--) begin
      for (int c = 0; c < NL; c++) if (en[c]) sdat_i[c] = w[c][b];
      repeat (3) @(negedge clk);
      if (push && b == 0)
        for (int c = 0; c < NL; c++) if (en[c]) push_exp(c, w[c]);
      sclk_i = sclk_i | en;
      repeat (5) @(negedge clk);
      sclk_i = sclk_i & ~en;
      repeat (4) @(negedge clk);
    end
  endtask

  // Reference comparison on every clock.
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NL; c++) begin
        if (burst_done_o[c] && !word_valid_o[c])
          chk(0, "R7 done without valid", 32'(burst_done_o[c]), 32'd0);
        if (word_valid_o[c]) begin
          seen_valid[c]++;
          if (burst_done_o[c]) seen_done[c]++;
          chk(!prev_valid[c], "R3 valid longer than one cycle", 32'd1, 32'd0);
          if (q_word[c].size() == 0) begin
            chk(0, $sformatf("R8 unexpected word on lane %0d", c), word_o[c], 32'd0);
          end else begin
            logic [31:0] ew; int ewi; int efi; bit ed;
            ew = q_word[c].pop_front(); ewi = q_widx[c].pop_front();
            efi = q_fidx[c].pop_front(); ed = q_done[c].pop_front();
            chk(word_o[c] == ew, $sformatf("R2 R4 word lane %0d", c), word_o[c], ew);
            chk(int'(word_idx_o[c]) == ewi, $sformatf("R5 word index lane %0d", c), 32'(word_idx_o[c]), 32'(ewi));
            chk(int'(frame_idx_o[c]) == efi, $sformatf("R6 frame index lane %0d", c), 32'(frame_idx_o[c]), 32'(efi));
            chk(burst_done_o[c] == ed, $sformatf("R7 burst done lane %0d", c), 32'(burst_done_o[c]), 32'(ed));
          end
        end
      end
    end
    prev_valid = rst ? '0 : word_valid_o;
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    finish_run();
  end

  initial begin
    logic [31:0] w [NL];
    int base;
    model_reset();
    for (int c = 0; c < NL; c++) begin seen_valid[c] = 0; seen_done[c] = 0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NL; c++) begin
      chk(word_valid_o[c] == 0 && burst_done_o[c] == 0, "R1 strobes after reset", 32'(word_valid_o[c]), 32'd0);
      chk(word_o[c] == 0 && word_idx_o[c] == 0 && frame_idx_o[c] == 0, "R1 outputs after reset", word_o[c], 32'd0);
    end

    // R8 and R2: only lane 2 active
    for (int c = 0; c < NL; c++) w[c] = 32'h8000_0001;
    send(5'b00100, w, 32, 1);
    for (int c = 0; c < NL; c++) w[c] = 32'hDEAD_BEEF;
    send(5'b00100, w, 32, 1);
    repeat (10) @(negedge clk);
    chk(seen_valid[2] == 2, "R8 lane 2 word count", 32'(seen_valid[2]), 32'd2);
    chk(seen_valid[0] + seen_valid[1] + seen_valid[3] + seen_valid[4] == 0, "R8 idle lanes silent",
        32'(seen_valid[0] + seen_valid[1] + seen_valid[3] + seen_valid[4]), 32'd0);

    // R2: data toggling without a serial clock edge is ignored
    base = seen_valid[2];
    for (int k = 0; k < 200; k++) begin sdat_i = ~sdat_i; @(negedge clk); end
    for (int c = 0; c < NL; c++) w[c] = 32'h1234_5678 ^ 32'(c);
    send(5'b11111, w, 32, 1);
    repeat (10) @(negedge clk);
    chk(seen_valid[2] == base + 1, "R2 data toggles ignored", 32'(seen_valid[2]), 32'(base + 1));

    // R1: reset in the middle of a word discards the partial bits
    for (int c = 0; c < NL; c++) w[c] = 32'hFFFF_FFFF;
    send(5'b11111, w, 20, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(word_o[0] == 0 && word_valid_o == 0, "R1 mid-word reset clears", word_o[0], 32'd0);
    for (int c = 0; c < NL; c++) begin seen_valid[c] = 0; seen_done[c] = 0; end

    // R5 R6 R7: full burst plus three more words on all lanes
    for (int n = 0; n < 133; n++) begin
      for (int c = 0; c < NL; c++) w[c] = $urandom;
      send(5'b11111, w, 32, 1);
    end
    repeat (10) @(negedge clk);
    for (int c = 0; c < NL; c++) begin
      chk(seen_done[c] == 1, "R7 one burst done per lane", 32'(seen_done[c]), 32'd1);
      chk(seen_valid[c] == 133, "R3 one word per 32 bits", 32'(seen_valid[c]), 32'd133);
      chk(q_word[c].size() == 0, "R3 all expected words seen", 32'(q_word[c].size()), 32'd0);
    end
    finish_run();
  end
endmodule